// File: doc/BRIEF.md
# DMA Control Register Decoder and Channel Service Arbiter

This block is the control front end of a four-channel DMA controller. A host writes byte-wide control words to eight write offsets and reads the status and mask bytes back over a simple strobe bus. The block holds the command byte, the per-channel mode bytes, the channel mask and a status byte. In the status byte, request flags sit in the upper nibble and terminal-count flags sit in the lower nibble.

Peripherals raise and drop their requests through per-channel hold and drop pulses. A transfer engine, which lies outside this block, reports terminal counts through per-channel pulses. On every cycle the block grants service to at most one channel. The grant goes to the lowest-numbered channel that is unmasked and requesting. The grant is registered, and it is forced to zero while the command's controller-disable bit is set. Clearing the byte pointer of the address and count registers is not done here: the block emits a one-cycle pulse, and the register file that holds the pointer consumes it.

Top module: `dma_ctl_arbiter`

## Requirements
- R1: A write to offset 0 stores wdata as the command byte only when wdata has no bit set other than bit 2. Any other value leaves the command unchanged. Command bit 2 is controller disable.
- R2: A write to offset 1 selects channel c = wdata[1:0]. It sets status bit c+4 to wdata[2], and it clears status bit c.
- R3: A write to offset 2 sets mask bit wdata[1:0] when wdata[2]=1 and clears it when wdata[2]=0. The other mask bits are unchanged.
- R4: A write to offset 3 stores the whole wdata byte as the mode of channel wdata[1:0]. Channel c's mode is presented on mode_bus[8c+7:8c]. Reset sets every mode to 0. A master clear does not change the modes.
- R5: A write to offset 4 produces a one-cycle high pulse on ptr_clr in the cycle after the write. A write to offset 5 produces the same pulse.
- R6: A write to offset 5 (master clear) and reset both set the mask to 4'hF and clear the status and the command.
- R7: A write to offset 6 clears all four mask bits. A write to offset 7 loads the mask from wdata[3:0].
- R8: A read of offset 0 returns the status byte and then clears status bits [3:0]. Bits [7:4] are kept. A read of offset 1 returns {4'b0, mask}. A read of any other offset returns 0. rdata is registered and is valid in the cycle after rd_en.
- R9: A pulse on hreq_hold[c] sets status bit c+4, and a pulse on hreq_drop[c] clears it. Drop wins when both pulses arrive together.
- R10: A pulse on tc_hit[c] sets status bit c.
- R11: grant is one-hot or zero. One cycle after the state changes, grant names the lowest channel c whose mask bit is 0 and whose status bit c+4 is 1.
- R12: While command bit 2 is set, grant is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 3 | Register offset for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| hreq_hold | input | 4 | Per-channel pulse that raises a hardware request |
| hreq_drop | input | 4 | Per-channel pulse that drops a hardware request |
| tc_hit | input | 4 | Per-channel terminal-count pulse from the transfer engine |
| mode_bus | output | 32 | Four stored mode bytes, channel 0 in the low byte |
| ptr_clr | output | 1 | One-cycle byte-pointer clear pulse |
| grant | output | 4 | Registered one-hot service grant |

## Verification
The arbiter is driven with several request and mask patterns. Two unmasked requesters check that the lower channel is chosen. Masking the winner checks that the grant moves up to the next requester. Setting the full mask, and then clearing it all, checks that the grant empties and refills. Hardware hold and drop pulses are checked against requests set by software write. Both sources must reach the same status bits and produce the same grants. Command values with a forbidden bit are applied while the disable bit is held. This separates rejecting a command from accepting it, because the grant only reappears after a clean command is written. Status reads are repeated with terminal-count and request flags present together. The repeat shows that reading clears only the low nibble.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int DMA_NCH  = 4;
  localparam int DMA_DW   = 8;
  localparam int DMA_AW   = 3;
  localparam int DMA_SELW = $clog2(DMA_NCH);
  localparam int CMD_DIS_BIT = 2;
  localparam logic [DMA_DW-1:0] CMD_ALLOWED = 8'h04;

  typedef enum logic [DMA_AW-1:0] {
    OFS_CMD     = 3'd0,
    OFS_SWREQ   = 3'd1,
    OFS_SMASK   = 3'd2,
    OFS_MODE    = 3'd3,
    OFS_PCLR    = 3'd4,
    OFS_MCLR    = 3'd5,
    OFS_UNMASK  = 3'd6,
    OFS_MASKALL = 3'd7
  } ofs_e;

  typedef struct packed {
    logic cmd;
    logic swreq;
    logic smask;
    logic mode;
    logic pclr;
    logic mclr;
    logic unmask;
    logic maskall;
  } wr_strobe_t;
endpackage

// File: rtl/dma_wr_decode.sv
module dma_wr_decode
  import dma_ctl_pkg::*;
(
  input  logic              wr_en,
  input  logic [DMA_AW-1:0] addr,
  output wr_strobe_t        st
);
  always_comb begin
    st = '0;
    if (wr_en) begin
      case (ofs_e'(addr))
        OFS_CMD:     st.cmd     = 1'b1;
        OFS_SWREQ:   st.swreq   = 1'b1;
        OFS_SMASK:   st.smask   = 1'b1;
        OFS_MODE:    st.mode    = 1'b1;
        OFS_PCLR:    st.pclr    = 1'b1;
        OFS_MCLR:    st.mclr    = 1'b1;
        OFS_UNMASK:  st.unmask  = 1'b1;
        OFS_MASKALL: st.maskall = 1'b1;
        default:     st = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_state_regs.sv
module dma_state_regs
  import dma_ctl_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  wr_strobe_t                st,
  input  logic                      rd_en,
  input  logic [DMA_AW-1:0]         addr,
  input  logic [DMA_DW-1:0]         wdata,
  input  logic [DMA_NCH-1:0]        hold_i,
  input  logic [DMA_NCH-1:0]        drop_i,
  input  logic [DMA_NCH-1:0]        tc_i,
  output logic [DMA_NCH-1:0]        mask_o,
  output logic [DMA_NCH-1:0]        req_o,
  output logic                      dis_o,
  output logic [DMA_NCH*DMA_DW-1:0] mode_o,
  output logic [DMA_DW-1:0]         rdata_o,
  output logic                      ptr_clr_o
);
  localparam int STW = 2 * DMA_NCH;

  logic [STW-1:0]     stat_q, stat_d;
  logic [DMA_NCH-1:0] mask_q, mask_d;
  logic [DMA_DW-1:0]  cmd_q, cmd_d;
  logic [DMA_DW-1:0]  rdata_q, rdata_d;
  logic               ptr_clr_q, ptr_clr_d;
  logic [DMA_SELW-1:0] sel;
  logic               cmd_ok;
  logic               rd_stat;

  assign sel     = wdata[DMA_SELW-1:0];
  assign cmd_ok  = (wdata & ~CMD_ALLOWED) == '0;
  assign rd_stat = rd_en && (ofs_e'(addr) == OFS_CMD);

  // status next state: read clear, hardware events, software request, master clear
  always_comb begin
    stat_d = stat_q;
    if (rd_stat) stat_d[DMA_NCH-1:0] = '0;
    for (int c = 0; c < DMA_NCH; c++) begin
      if (hold_i[c]) stat_d[c+DMA_NCH] = 1'b1;
      if (drop_i[c]) stat_d[c+DMA_NCH] = 1'b0;
      if (tc_i[c])   stat_d[c]         = 1'b1;
    end
    if (st.swreq) begin
      stat_d[int'(sel)+DMA_NCH] = wdata[2];
      stat_d[int'(sel)]         = 1'b0;
    end
    if (st.mclr) stat_d = '0;
  end

  always_comb begin
    mask_d = mask_q;
    if (st.smask)   mask_d[sel] = wdata[2];
    if (st.unmask)  mask_d = '0;
    if (st.maskall) mask_d = wdata[DMA_NCH-1:0];
    if (st.mclr)    mask_d = '1;
  end

  always_comb begin
    cmd_d = cmd_q;
    if (st.cmd && cmd_ok) cmd_d = wdata;
    if (st.mclr)          cmd_d = '0;
  end

  always_comb begin
    case (ofs_e'(addr))
      OFS_CMD:   rdata_d = stat_q;
      OFS_SWREQ: rdata_d = {{(DMA_DW-DMA_NCH){1'b0}}, mask_q};
      default:   rdata_d = '0;
    endcase
  end

  assign ptr_clr_d = st.pclr | st.mclr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= '0;
      mask_q    <= '1;
      cmd_q     <= '0;
      rdata_q   <= '0;
      ptr_clr_q <= 1'b0;
    end else begin
      stat_q    <= stat_d;
      mask_q    <= mask_d;
      cmd_q     <= cmd_d;
      ptr_clr_q <= ptr_clr_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  // per-channel mode bytes with explicit enables
  for (genvar c = 0; c < DMA_NCH; c++) begin : g_mode
    logic [DMA_DW-1:0] mode_q;
    logic              mode_en;
    assign mode_en = st.mode && (sel == c[DMA_SELW-1:0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_en) mode_q <= wdata;
    end
    assign mode_o[c*DMA_DW +: DMA_DW] = mode_q;
  end

  assign mask_o    = mask_q;
  assign req_o     = stat_q[STW-1:DMA_NCH];
  assign dis_o     = cmd_q[CMD_DIS_BIT];
  assign rdata_o   = rdata_q;
  assign ptr_clr_o = ptr_clr_q;

  assert_mclr_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st.mclr) |-> (mask_q == '1 && stat_q == '0 && cmd_q == '0));

  assert_cmd_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st.cmd && !cmd_ok) |-> $stable(cmd_q));

  assert_rd_clears_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_stat && tc_i == '0) |-> (stat_q[DMA_NCH-1:0] == '0));

  assert_ptr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st.pclr) |-> ptr_clr_o);
endmodule

// File: rtl/dma_prio_grant.sv
module dma_prio_grant
  import dma_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DMA_NCH-1:0] mask_i,
  input  logic [DMA_NCH-1:0] req_i,
  input  logic               dis_i,
  output logic [DMA_NCH-1:0] grant_o
);
  logic [DMA_NCH-1:0] elig, seen, pick;
  logic [DMA_NCH-1:0] grant_q, grant_d;

  assign elig = req_i & ~mask_i;

  for (genvar c = 0; c < DMA_NCH; c++) begin : g_scan
    if (c == 0) begin : g_first
      assign seen[c] = elig[c];
      assign pick[c] = elig[c];
    end else begin : g_rest
      assign seen[c] = seen[c-1] | elig[c];
      assign pick[c] = elig[c] & ~seen[c-1];
    end
  end

  always_comb begin
    grant_d = dis_i ? '0 : pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= '0;
    else        grant_q <= grant_d;
  end

  assign grant_o = grant_q;

  assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));

  assert_grant_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q & ($past(mask_i) | ~$past(req_i))) == '0);

  assert_grant_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dis_i) |-> (grant_q == '0));
endmodule

// File: rtl/dma_ctl_arbiter.sv
module dma_ctl_arbiter
  import dma_ctl_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [DMA_AW-1:0]         addr,
  input  logic [DMA_DW-1:0]         wdata,
  output logic [DMA_DW-1:0]         rdata,
  input  logic [DMA_NCH-1:0]        hreq_hold,
  input  logic [DMA_NCH-1:0]        hreq_drop,
  input  logic [DMA_NCH-1:0]        tc_hit,
  output logic [DMA_NCH*DMA_DW-1:0] mode_bus,
  output logic                      ptr_clr,
  output logic [DMA_NCH-1:0]        grant
);
  logic [1:0]         rsync_q;
  logic               rst_n_i;
  wr_strobe_t         st;
  logic [DMA_NCH-1:0] mask_w, req_w;
  logic               dis_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_i = rsync_q[1];

  dma_wr_decode u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .st    (st)
  );

  dma_state_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .st        (st),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .hold_i    (hreq_hold),
    .drop_i    (hreq_drop),
    .tc_i      (tc_hit),
    .mask_o    (mask_w),
    .req_o     (req_w),
    .dis_o     (dis_w),
    .mode_o    (mode_bus),
    .rdata_o   (rdata),
    .ptr_clr_o (ptr_clr)
  );

  dma_prio_grant u_arb (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .mask_i  (mask_w),
    .req_i   (req_w),
    .dis_i   (dis_w),
    .grant_o (grant)
  );
endmodule

// File: tb/dma_ctl_arbiter_tb.sv
module dma_ctl_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  hreq_hold = '0;
  logic [3:0]  hreq_drop = '0;
  logic [3:0]  tc_hit = '0;
  logic [31:0] mode_bus;
  logic        ptr_clr;
  logic [3:0]  grant;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dma_ctl_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .hreq_hold(hreq_hold), .hreq_drop(hreq_drop),
    .tc_hit(tc_hit), .mode_bus(mode_bus), .ptr_clr(ptr_clr), .grant(grant)
  );

  // op: 0 write, 1 read and compare rdata, 2 wait a cycle and compare grant
  localparam int NV = 22;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 3'd6, 8'h00, 8'h00},  // R7 clear all masks
    {2'd0, 3'd1, 8'h04, 8'h00},  // R2 request ch0
    {2'd2, 3'd0, 8'h00, 8'h01},  // R11 ch0 granted
    {2'd0, 3'd1, 8'h06, 8'h00},  // R2 request ch2
    {2'd2, 3'd0, 8'h00, 8'h01},  // R11 lowest wins
    {2'd0, 3'd2, 8'h04, 8'h00},  // R3 mask ch0
    {2'd2, 3'd0, 8'h00, 8'h04},  // R11 ch2 now
    {2'd1, 3'd1, 8'h00, 8'h01},  // R3 mask readback
    {2'd0, 3'd7, 8'h0B, 8'h00},  // R7 load mask 1011
    {2'd2, 3'd0, 8'h00, 8'h04},
    {2'd0, 3'd7, 8'h0F, 8'h00},  // R7 all masked
    {2'd2, 3'd0, 8'h00, 8'h00},
    {2'd0, 3'd6, 8'h00, 8'h00},  // R7 unmask all
    {2'd2, 3'd0, 8'h00, 8'h01},
    {2'd1, 3'd0, 8'h00, 8'h50},  // R8 status ch0,ch2 requests
    {2'd0, 3'd1, 8'h00, 8'h00},  // R2 clear ch0 request
    {2'd2, 3'd0, 8'h00, 8'h04},
    {2'd0, 3'd0, 8'h04, 8'h00},  // R12 disable
    {2'd2, 3'd0, 8'h00, 8'h00},
    {2'd0, 3'd0, 8'h01, 8'h00},  // R1 rejected (bit0)
    {2'd2, 3'd0, 8'h00, 8'h00},
    {2'd1, 3'd3, 8'h00, 8'h00}   // R8 other offset reads 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    do_reset();
    // reset state, R6
    rd(3'd1, v); chk("R6 reset mask", v, 8'h0F);
    rd(3'd0, v); chk("R6 reset status", v, 8'h00);
    chk("R11 reset grant", grant, 4'h0);
    chk("R4 reset modes", mode_bus, 32'h0);
    chk("R5 reset ptr_clr", ptr_clr, 1'b0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][20:19])
        2'd0: wr(VEC[i][18:16], VEC[i][15:8]);
        2'd1: begin
          rd(VEC[i][18:16], v);
          chk($sformatf("R8 vec %0d rdata", i), v, VEC[i][7:0]);
        end
        default: begin
          @(negedge clk);
          chk($sformatf("R11 vec %0d grant", i), grant, VEC[i][3:0]);
        end
      endcase
    end

    // R1: clean command accepted, grant returns
    wr(3'd0, 8'h14); @(negedge clk); chk("R1 reject 0x14", grant, 4'h0);
    wr(3'd0, 8'h00); @(negedge clk); chk("R1 accept 0x00", grant, 4'h4);
    wr(3'd1, 8'h02); @(negedge clk); chk("R2 clear ch2 req", grant, 4'h0);

    // R4 mode storage
    wr(3'd3, 8'h96);
    wr(3'd3, 8'h4B);
    chk("R4 modes", mode_bus, 32'h4B96_0000);

    // R5 pointer clear pulse
    wr(3'd4, 8'h00);
    chk("R5 ptr_clr high", ptr_clr, 1'b1);
    @(negedge clk); chk("R5 ptr_clr low", ptr_clr, 1'b0);

    // R9 hardware hold/drop
    @(negedge clk); hreq_hold = 4'h8; @(negedge clk); hreq_hold = 4'h0;
    @(negedge clk); chk("R9 hold grant", grant, 4'h8);
    @(negedge clk); hreq_hold = 4'h2; hreq_drop = 4'h2; @(negedge clk);
    hreq_hold = 4'h0; hreq_drop = 4'h0;
    @(negedge clk); chk("R9 drop wins", grant, 4'h8);
    @(negedge clk); hreq_drop = 4'h8; @(negedge clk); hreq_drop = 4'h0;
    @(negedge clk); chk("R9 drop grant", grant, 4'h0);

    // R10 / R8: terminal count with a live request
    @(negedge clk); hreq_hold = 4'h8; tc_hit = 4'h2; @(negedge clk);
    hreq_hold = 4'h0; tc_hit = 4'h0;
    rd(3'd0, v); chk("R10 tc status", v, 8'h82);
    rd(3'd0, v); chk("R8 low nibble cleared", v, 8'h80);
    // R2: offset 1 clears tc bit
    @(negedge clk); tc_hit = 4'h1; @(negedge clk); tc_hit = 4'h0;
    wr(3'd1, 8'h04);
    rd(3'd0, v); chk("R2 tc cleared by request write", v, 8'h90);

    // R6 master clear
    wr(3'd0, 8'h04);
    wr(3'd5, 8'h00);
    chk("R5 mclr ptr_clr", ptr_clr, 1'b1);
    rd(3'd1, v); chk("R6 mclr mask", v, 8'h0F);
    rd(3'd0, v); chk("R6 mclr status", v, 8'h00);
    chk("R4 modes kept by mclr", mode_bus, 32'h4B96_0000);
    wr(3'd6, 8'h00); wr(3'd1, 8'h05);
    @(negedge clk); chk("R6 mclr cleared disable", grant, 4'h2);

    // R6 reset mid-run
    do_reset();
    rd(3'd1, v); chk("R6 mid-run reset mask", v, 8'h0F);
    chk("R6 mid-run reset grant", grant, 4'h0);
    chk("R4 mid-run reset modes", mode_bus, 32'h0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule